// File: doc/BRIEF.md
# Wakeup Counter with Alarm and Periodic Compare

A memory-mapped wakeup timer. A 32-bit counter advances on ticks taken from one of four tick-enable inputs. Each tick can first pass through two optional fixed prescalers, a divide-by-512 stage followed by a divide-by-32 stage. The counter cannot be written. It wraps from all-ones to zero and is held at zero while disabled, so every enable starts a fresh count from zero.

The counter feeds two compare paths. The alarm path raises a sticky flag when the count reaches a nonzero compare value. The periodic path raises a sticky flag each time a programmed number of counter ticks has elapsed since its last event. Each path has its own enable, interrupt enable and write-one-to-clear flag, and the two gated flags are ORed into one interrupt line.

Software reaches the block through a single-cycle 32-bit register port. Writes are strobed by `bus_sel` with `bus_wr`, and reads return combinationally. A busy status bit guards the alarm register for a short window after each alarm write and after the counter is switched on.

Top module: `wake_timer`

## Requirements
- R1: After reset, every readable register returns 0 and `irq` is low. Register offsets are: control 0x00, status 0x04, count 0x08 (read-only; writes to it are ignored), interval 0x0C, alarm 0x10.
- R2: While control bit 31 (run) is 1, the count increments by one per divided tick. While run is 0, the count reads 0, so switching run off and on restarts counting from zero.
- R3: Control bits 13:12 select which `tick_src` bit drives the counter. Selection value 1 is reserved, and with it the counter never advances.
- R4: Control bit 11 divides the selected ticks by 512 and bit 10 divides them by 32. With both set, the two stages cascade for a division of 16384.
- R5: While run is already 1, writes to control leave bits 13:10 unchanged. The other control bits are still written.
- R6: Status bit 29 (alarm flag) is set on the tick that makes the count equal to a nonzero alarm value. An alarm value of 0 never sets it.
- R7: Status bit 18 (busy) is 1 for 3 ticks of the selected source after an accepted alarm write, or after run goes from 0 to 1. An alarm write while busy is 1 is ignored.
- R8: When control bit 15 is set and the interval is nonzero, status bit 13 (periodic flag) is set after every interval-count counter ticks. An interval of 0 produces no events.
- R9: Writing 1 to status bit 29 or bit 13 clears that flag. Writing 0 to a flag bit leaves that flag unchanged.
- R10: `irq` is high exactly when (alarm flag and control bit 30) or (periodic flag and control bit 14).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when high, read when low |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| tick_src | input | 4 | Tick-enable pulses from the four sources |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest state to reach is a full cascade of both prescalers. Reaching it takes 16384 source pulses, with the count required to stay at zero on all but the last. The stimulus drives exactly 16383 single-cycle pulses, then one more, and checks the count at both points. The busy window is also awkward, because it advances on source ticks and not on clocks. The stimulus first provokes it with no ticks so that it stays open, proves an alarm write is dropped, and then pulses the source exactly three times before the next alarm write.

// File: rtl/wake_timer.sv
module wake_timer #(
  parameter int ADDR_W     = 5,
  parameter int PRE_HI_LOG = 9,
  parameter int PRE_LO_LOG = 5,
  parameter int BUSY_TICKS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [3:0]        tick_src,
  output logic              irq
);
  localparam int BUSY_W = $clog2(BUSY_TICKS + 1);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_INT  = ADDR_W'(12);
  localparam logic [ADDR_W-1:0] A_ALM  = ADDR_W'(16);

  logic run_q, aie_q, pen_q, pie_q, pre_hi_q, pre_lo_q;
  logic [1:0] src_q;
  logic [31:0] count_q, interval_q, alarm_q, pcnt_q;
  logic [PRE_HI_LOG-1:0] hi_q;
  logic [PRE_LO_LOG-1:0] lo_q;
  logic [BUSY_W-1:0] busy_q;
  logic aflag_q, pflag_q;

  logic wr, wr_ctrl, wr_stat, wr_int, wr_alm;
  assign wr      = bus_sel & bus_wr;
  assign wr_ctrl = wr & (bus_addr == A_CTRL);
  assign wr_stat = wr & (bus_addr == A_STAT);
  assign wr_int  = wr & (bus_addr == A_INT);
  assign wr_alm  = wr & (bus_addr == A_ALM);

  logic raw_tick, stage1, stage2, cnt_tick;
  assign raw_tick = tick_src[src_q] & (src_q != 2'd1);
  assign stage1   = pre_hi_q ? (raw_tick & (&hi_q)) : raw_tick;
  assign stage2   = pre_lo_q ? (stage1 & (&lo_q)) : stage1;
  assign cnt_tick = run_q & stage2;

  logic busy, alarm_take, run_rise, alarm_hit, per_active, per_hit;
  logic [31:0] count_nx, pcnt_nx;
  assign busy       = (busy_q != '0);
  assign alarm_take = wr_alm & ~busy;
  assign run_rise   = wr_ctrl & bus_wdata[31] & ~run_q;
  assign count_nx   = count_q + 32'd1;
  assign pcnt_nx    = pcnt_q + 32'd1;
  assign alarm_hit  = cnt_tick & (alarm_q != '0) & (count_nx == alarm_q);
  assign per_active = run_q & pen_q & (interval_q != '0);
  assign per_hit    = per_active & cnt_tick & (pcnt_nx == interval_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0; aie_q <= 1'b0; pen_q <= 1'b0; pie_q <= 1'b0;
      src_q <= 2'd0; pre_hi_q <= 1'b0; pre_lo_q <= 1'b0;
    end else if (wr_ctrl) begin
      run_q <= bus_wdata[31];
      aie_q <= bus_wdata[30];
      pen_q <= bus_wdata[15];
      pie_q <= bus_wdata[14];
      if (!run_q) begin
        src_q    <= bus_wdata[13:12];
        pre_hi_q <= bus_wdata[11];
        pre_lo_q <= bus_wdata[10];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0; lo_q <= '0;
    end else if (!run_q) begin
      hi_q <= '0; lo_q <= '0;
    end else begin
      if (pre_hi_q && raw_tick) hi_q <= hi_q + 1'b1;
      if (pre_lo_q && stage1)   lo_q <= lo_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (!run_q)   count_q <= '0;
    else if (stage2)   count_q <= count_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           pcnt_q <= '0;
    else if (!per_active) pcnt_q <= '0;
    else if (cnt_tick)    pcnt_q <= per_hit ? '0 : pcnt_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    busy_q <= '0;
    else if (alarm_take | run_rise) busy_q <= BUSY_W'(BUSY_TICKS);
    else if (busy && raw_tick)     busy_q <= busy_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_q <= '0; interval_q <= '0;
    end else begin
      if (alarm_take) alarm_q <= bus_wdata;
      if (wr_int)     interval_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aflag_q <= 1'b0; pflag_q <= 1'b0;
    end else begin
      aflag_q <= alarm_hit | (aflag_q & ~(wr_stat & bus_wdata[29]));
      pflag_q <= per_hit   | (pflag_q & ~(wr_stat & bus_wdata[13]));
    end
  end

  assign irq = (aflag_q & aie_q) | (pflag_q & pie_q);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: begin
        bus_rdata[31] = run_q;   bus_rdata[30] = aie_q;
        bus_rdata[15] = pen_q;   bus_rdata[14] = pie_q;
        bus_rdata[13:12] = src_q;
        bus_rdata[11] = pre_hi_q; bus_rdata[10] = pre_lo_q;
      end
      A_STAT: begin
        bus_rdata[29] = aflag_q;
        bus_rdata[18] = busy;
        bus_rdata[13] = pflag_q;
      end
      A_CNT:   bus_rdata = count_q;
      A_INT:   bus_rdata = interval_q;
      A_ALM:   bus_rdata = alarm_q;
      default: bus_rdata = '0;
    endcase
  end

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> count_q == '0); // R2
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !stage2) |=> $stable(count_q)); // R2
  AST_RSV_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && src_q == 2'd1) |=> $stable(count_q)); // R3
  AST_CFG_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && run_q) |=> $stable(src_q) && $stable(pre_hi_q) && $stable(pre_lo_q)); // R5
  AST_ZERO_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_q == '0 && !aflag_q) |=> !aflag_q); // R6
  AST_BUSY_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_alm && busy) |=> $stable(alarm_q)); // R7
  AST_NO_PER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!per_active && !pflag_q) |=> !pflag_q); // R8
  AST_W1C_ALARM: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && bus_wdata[29] && !alarm_hit) |=> !aflag_q); // R9
endmodule

// File: tb/tb_wake_timer.sv
module tb_wake_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0] tick_src = '0;
  logic irq;
  int n_chk = 0, n_bad = 0;
  logic [31:0] rv;

  always #2 clk = ~clk;

  wake_timer dut (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
                  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
                  .tick_src(tick_src), .irq(irq));

  localparam logic [4:0] CTRL = 5'h00, STAT = 5'h04, CNT = 5'h08, INTV = 5'h0C, ALM = 5'h10;

  // {address, write data, expected readback}
  localparam logic [68:0] VEC [0:6] = '{
    {INTV, 32'h0000_0005, 32'h0000_0005},
    {CTRL, 32'h0000_3C00, 32'h0000_3C00},
    {CTRL, 32'h8000_0000, 32'h8000_0000},
    {CTRL, 32'h8000_3C00, 32'h8000_0000},
    {ALM,  32'h0000_0077, 32'h0000_0000},
    {CTRL, 32'h0000_0000, 32'h0000_0000},
    {INTV, 32'h0000_0000, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pulse(input logic [3:0] m, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_src = m;
      @(negedge clk); tick_src = '0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(CTRL, rv); check("R1 ctrl", rv, 0);
    rd(STAT, rv); check("R1 status", rv, 0);
    rd(CNT, rv);  check("R1 count", rv, 0);
    rd(ALM, rv);  check("R1 alarm", rv, 0);
    check("R1 irq", {31'b0, irq}, 0);

    // table: write then read back (R5 lock, R7 busy drop)
    for (int i = 0; i < 7; i++) begin
      wr(VEC[i][68:64], VEC[i][63:32]);
      rd(VEC[i][68:64], rv);
      check("R5/R7 table", rv, VEC[i][31:0]);
    end

    // R7 busy persists without ticks, clears after 3 source ticks
    rd(STAT, rv); check("R7 busy held", {31'b0, rv[18]}, 1);
    pulse(4'b0001, 3);
    rd(STAT, rv); check("R7 busy cleared", {31'b0, rv[18]}, 0);
    wr(ALM, 32'd5);
    rd(ALM, rv); check("R7 alarm accepted", rv, 5);

    // R6 alarm, R10 irq
    wr(CTRL, 32'hC000_0000);
    pulse(4'b0001, 4);
    rd(STAT, rv); check("R6 not yet", {31'b0, rv[29]}, 0);
    pulse(4'b0001, 1);
    rd(CNT, rv); check("R2 count five", rv, 5);
    rd(STAT, rv); check("R6 alarm flag", {31'b0, rv[29]}, 1);
    check("R10 irq alarm", {31'b0, irq}, 1);
    wr(STAT, 32'h0000_2000);
    rd(STAT, rv); check("R9 zero write keeps", {31'b0, rv[29]}, 1);
    wr(STAT, 32'h2000_0000);
    rd(STAT, rv); check("R9 clear alarm", {31'b0, rv[29]}, 0);
    check("R10 irq drop", {31'b0, irq}, 0);

    // R8 periodic
    wr(INTV, 32'd3);
    wr(CTRL, 32'hC000_C000);
    pulse(4'b0001, 3);
    rd(STAT, rv); check("R8 periodic flag", {31'b0, rv[13]}, 1);
    check("R10 irq periodic", {31'b0, irq}, 1);
    wr(CTRL, 32'hC000_8000);
    check("R10 gated off", {31'b0, irq}, 0);
    wr(STAT, 32'h0000_2000);
    pulse(4'b0001, 2);
    rd(STAT, rv); check("R8 mid interval", {31'b0, rv[13]}, 0);
    pulse(4'b0001, 1);
    rd(STAT, rv); check("R8 second event", {31'b0, rv[13]}, 1);
    wr(STAT, 32'h0000_2000);
    wr(INTV, 32'd0);
    pulse(4'b0001, 4);
    rd(STAT, rv); check("R8 zero interval", {31'b0, rv[13]}, 0);

    // R2 disable resets, R1 count read-only
    wr(CTRL, 32'h0);
    rd(CNT, rv); check("R2 disable zero", rv, 0);
    wr(CTRL, 32'h8000_0000);
    pulse(4'b0001, 2);
    wr(CNT, 32'h0000_FFFF);
    rd(CNT, rv); check("R1 count read-only", rv, 2);

    // R3 reserved and alternate source
    wr(CTRL, 32'h0);
    wr(CTRL, 32'h8000_1000);
    pulse(4'b1111, 3);
    rd(CNT, rv); check("R3 reserved stopped", rv, 0);
    wr(CTRL, 32'h0);
    wr(CTRL, 32'h8000_2000);
    pulse(4'b0001, 3);
    rd(CNT, rv); check("R3 other source ignored", rv, 0);
    pulse(4'b0100, 2);
    rd(CNT, rv); check("R3 source two", rv, 2);
    wr(CTRL, 32'h8000_0000);
    rd(CTRL, rv); check("R5 source locked", rv, 32'h8000_2000);

    // R4 prescalers
    wr(CTRL, 32'h0);
    wr(CTRL, 32'h8000_0400);
    pulse(4'b0001, 31);
    rd(CNT, rv); check("R4 div32 early", rv, 0);
    pulse(4'b0001, 1);
    rd(CNT, rv); check("R4 div32", rv, 1);
    wr(CTRL, 32'h0);
    wr(CTRL, 32'h8000_0800);
    pulse(4'b0001, 511);
    rd(CNT, rv); check("R4 div512 early", rv, 0);
    pulse(4'b0001, 1);
    rd(CNT, rv); check("R4 div512", rv, 1);
    wr(CTRL, 32'h0);
    wr(CTRL, 32'h8000_0C00);
    pulse(4'b0001, 16383);
    rd(CNT, rv); check("R4 cascade early", rv, 0);
    pulse(4'b0001, 1);
    rd(CNT, rv); check("R4 cascade", rv, 1);

    // R6 zero disarms
    wr(CTRL, 32'h0);
    wr(CTRL, 32'h8000_0000);
    pulse(4'b0001, 3);
    wr(ALM, 32'd0);
    pulse(4'b0001, 4);
    rd(CNT, rv); check("R6 passed old alarm", rv, 7);
    rd(STAT, rv); check("R6 disarmed", {31'b0, rv[29]}, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule